// File: doc/BRIEF.md
# Dual-Quad Register Access Mapper

This block sits between a decoded host bus and the register state of an eight-channel power controller. The controller's registers are laid out as two four-channel register spaces, called quads. Each quad keeps its own copy of the mode, watchdog and channel registers. A bus transaction reaches the block already decoded into four fields: the least significant bit of the device address (A0), a command code, the index of the byte within the current multi-byte transfer, and, for writes, a data byte. The block routes the access to the right quad or measurement source and returns the read byte one clock later.

The block has two access modes. In narrow mode each quad answers at its own bus address and A0 selects the quad. In wide mode only the A0 = 0 address answers, and a transfer carries both quads side by side. For an 8-bit register, byte 0 belongs to the lower quad and byte 1 to the upper quad. For channel measurements, 2-byte and 4-byte reads place the lower-quad and upper-quad channel values one after the other. The block also merges the per-quad copies of the global controls into one set of outputs: the access mode, the priority scheme and the watchdog enable. It exposes the block-RAM control and start address, which only the lower quad holds.

Top module: `dq_reg_mapper`

## Requirements
- R1: In narrow mode, A0 selects the quad (0 gives channels 1-4, 1 gives channels 5-8). An 8-bit register answers only at byte index 0; any other index reads 0x00 and its write is ignored.
- R2: In wide mode, byte index 0 addresses the lower quad and byte index 1 the upper quad. Indices 2 and 3 read 0x00 for 8-bit registers. An access with A0 = 1 reads 0x00 and its writes have no effect.
- R3: Each quad holds a mode register at command 0x17 with reset value 0x80. Bit 0 of this register is the wide-access bit. `wide_mode_o` is high while either quad's copy of bit 0 is set, and it drops only after both copies are cleared.
- R4: Bit 1 of the mode register selects the multi-bit priority scheme. `multi_prio_o` is high while either quad's copy of bit 1 is set.
- R5: Command 0x11 is a read-only pin status register laid out as {3'b000, strap_i[3:0], a0}. In narrow mode a0 is 0 for the lower quad and 1 for the upper quad; in wide mode a0 is 0 in both bytes.
- R6: Channel c (0..3 within a quad) reports its current at command 0x30+4c and its voltage at 0x32+4c. Byte index 0 holds the low byte and index 1 the high byte. In narrow mode A0 picks the quad. Odd measurement commands and byte indices 2 and 3 read 0x00.
- R7: In wide mode, a read at an even measurement command returns the lower-quad channel value in bytes 0-1 and the upper-quad channel (c+4) in bytes 2-3.
- R8: In wide mode, a read at the odd command (even command + 1) returns the upper-quad channel value in bytes 0-1; bytes 2-3 read 0x00.
- R9: Each quad holds a watchdog register at command 0x42 with reset value 0x0B; its field is bits [3:0]. `wdog_en_o` is high when either quad's field differs from 1011b.
- R10: Block-RAM control (0x60), start-address low (0x62) and start-address high (0x63) exist only in the lower quad and drive `sram_ctl_o` and `sram_addr_o`. In the upper quad they read 0x00 and their writes are ignored.
- R11: Command 0x2C returns `temp_i` identically from both quads. Writes to 0x2C, 0x11 and the measurement commands are ignored.
- R12: Commands with no mapped register read 0x00, and writes to them change no state.
- R13: `rdata_o` updates on the clock edge that takes a read transaction and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_valid_i | input | 1 | Decoded transaction present this cycle |
| txn_wr_i | input | 1 | 1 = write, 0 = read |
| dev_a0_i | input | 1 | Device address least significant bit |
| cmd_i | input | 8 | Command code |
| bidx_i | input | 2 | Byte index within the transfer |
| wdata_i | input | 8 | Write data byte |
| strap_i | input | STRAP_W | Address strap pins reported in pin status |
| temp_i | input | 8 | Shared die temperature code |
| cur_i | input | NCH*MEAS_W | Channel currents, channel n at [n*MEAS_W +: MEAS_W] |
| volt_i | input | NCH*MEAS_W | Channel voltages, same packing |
| rdata_o | output | 8 | Registered read byte |
| wide_mode_o | output | 1 | Merged wide-access mode |
| multi_prio_o | output | 1 | Merged multi-bit priority select |
| wdog_en_o | output | 1 | Merged watchdog enable |
| sram_ctl_o | output | 8 | Lower-quad block-RAM control |
| sram_addr_o | output | 16 | Lower-quad block-RAM start address |

## Verification
The routing is exercised first with directed sequences, then with a long random mix of reads and writes at A0 = 0 and A0 = 1. The commands cover every mapped code plus unmapped ones, and all four byte indices are used. Because random writes to the mode register keep switching the block between narrow and wide mode, the same command and byte index are seen under both decodings. Two kinds of mismatch are told apart this way: a wrong quad choice shows up as the other quad's data, and a wrong measurement join shows up as a swapped or missing channel. Directed cases cover setting and clearing the mode bits in each quad separately, the A0 report in pin status, the watchdog field at and away from 1011b, and writes to the block-RAM registers in the upper quad.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam logic [7:0] CMD_PIN      = 8'h11;
  localparam logic [7:0] CMD_GMASK    = 8'h17;
  localparam logic [7:0] CMD_TEMP     = 8'h2C;
  localparam logic [7:0] CMD_WDOG     = 8'h42;
  localparam logic [7:0] CMD_SRAM_CTL = 8'h60;
  localparam logic [7:0] CMD_SRAM_ALO = 8'h62;
  localparam logic [7:0] CMD_SRAM_AHI = 8'h63;
  localparam logic [3:0] MEAS_NIB     = 4'h3;

  localparam int GM_WIDE_BIT = 0;
  localparam int GM_MPRI_BIT = 1;
  localparam logic [7:0] GM_RST = 8'h80;
  localparam logic [7:0] WD_RST = 8'h0B;
  localparam logic [3:0] WD_OFF = 4'hB;

  typedef struct packed {
    logic hit;
    logic quad;
  } reg_route_t;

  typedef struct packed {
    logic       hit;
    logic [2:0] ch;
    logic       volt;
    logic       hi;
  } meas_route_t;
endpackage

// File: rtl/dq_route.sv
module dq_route
  import dq_pkg::*;
(
  input  logic        wide_i,
  input  logic        a0_i,
  input  logic [7:0]  cmd_i,
  input  logic [1:0]  bidx_i,
  output reg_route_t  reg_o,
  output meas_route_t meas_o
);
  logic is_meas;
  assign is_meas = (cmd_i[7:4] == MEAS_NIB);

  always_comb begin
    reg_o  = '0;
    meas_o = '0;
    meas_o.ch[1:0] = cmd_i[3:2];
    meas_o.volt    = cmd_i[1];
    meas_o.hi      = bidx_i[0];
    if (!wide_i) begin
      reg_o.hit     = !is_meas && (bidx_i == 2'd0);
      reg_o.quad    = a0_i;
      meas_o.hit    = is_meas && !cmd_i[0] && !bidx_i[1];
      meas_o.ch[2]  = a0_i;
    end else begin
      reg_o.hit     = !is_meas && !a0_i && !bidx_i[1];
      reg_o.quad    = bidx_i[0];
      // odd code starts at the upper-quad value; even code joins lower then upper
      meas_o.hit    = is_meas && !a0_i && !(cmd_i[0] && bidx_i[1]);
      meas_o.ch[2]  = cmd_i[0] | bidx_i[1];
    end
  end
endmodule

// File: rtl/dq_meas_mux.sv
module dq_meas_mux
  import dq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int MEAS_W = 16
) (
  input  logic [NCH*MEAS_W-1:0] cur_i,
  input  logic [NCH*MEAS_W-1:0] volt_i,
  input  meas_route_t           sel_i,
  output logic [7:0]            rdata_o
);
  localparam int CH_W = $clog2(NCH);
  logic [MEAS_W-1:0] val;
  logic [CH_W-1:0]   ch;

  assign ch  = CH_W'(sel_i.ch);
  assign val = sel_i.volt ? volt_i[ch*MEAS_W +: MEAS_W] : cur_i[ch*MEAS_W +: MEAS_W];
  assign rdata_o = sel_i.hi ? val[8 +: 8] : val[7:0];
endmodule

// File: rtl/dq_quad_regs.sv
module dq_quad_regs
  import dq_pkg::*;
#(
  parameter int QUAD_ID  = 0,
  parameter bit HAS_SRAM = 1'b1,
  parameter int STRAP_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         cmd_i,
  input  logic [7:0]         wdata_i,
  input  logic               wide_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [7:0]         temp_i,
  output logic [7:0]         rdata_o,
  output logic               wide_o,
  output logic               mprio_o,
  output logic               wdog_off_o,
  output logic [7:0]         sram_ctl_o,
  output logic [15:0]        sram_addr_o
);
  localparam logic QUAD_A0 = (QUAD_ID % 2) != 0;
  localparam int   PAD_W   = 7 - STRAP_W;

  logic [7:0] gm_q, wd_q;
  logic [7:0] pin_stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gm_q <= GM_RST;
      wd_q <= WD_RST;
    end else if (wr_i) begin
      if (cmd_i == CMD_GMASK) gm_q <= wdata_i;
      if (cmd_i == CMD_WDOG)  wd_q <= wdata_i;
    end
  end

  generate
    if (HAS_SRAM) begin : g_sram
      logic [7:0]  ctl_q;
      logic [15:0] addr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ctl_q  <= '0;
          addr_q <= '0;
        end else if (wr_i) begin
          if (cmd_i == CMD_SRAM_CTL) ctl_q        <= wdata_i;
          if (cmd_i == CMD_SRAM_ALO) addr_q[7:0]  <= wdata_i;
          if (cmd_i == CMD_SRAM_AHI) addr_q[15:8] <= wdata_i;
        end
      end
      assign sram_ctl_o  = ctl_q;
      assign sram_addr_o = addr_q;
    end else begin : g_no_sram
      assign sram_ctl_o  = '0;
      assign sram_addr_o = '0;
    end
  endgenerate

  assign pin_stat   = {{PAD_W{1'b0}}, strap_i, (wide_i ? 1'b0 : QUAD_A0)};
  assign wide_o     = gm_q[GM_WIDE_BIT];
  assign mprio_o    = gm_q[GM_MPRI_BIT];
  assign wdog_off_o = (wd_q[3:0] == WD_OFF);

  always_comb begin
    unique case (cmd_i)
      CMD_GMASK:    rdata_o = gm_q;
      CMD_WDOG:     rdata_o = wd_q;
      CMD_PIN:      rdata_o = pin_stat;
      CMD_TEMP:     rdata_o = temp_i;
      CMD_SRAM_CTL: rdata_o = sram_ctl_o;
      CMD_SRAM_ALO: rdata_o = sram_addr_o[7:0];
      CMD_SRAM_AHI: rdata_o = sram_addr_o[15:8];
      default:      rdata_o = 8'h00;
    endcase
  end

  // R9
  wdog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && cmd_i == CMD_WDOG) |=> $stable(wdog_off_o));
endmodule

// File: rtl/dq_reg_mapper.sv
module dq_reg_mapper
  import dq_pkg::*;
#(
  parameter int CH_PER_QUAD = 4,
  parameter int MEAS_W      = 16,
  parameter int STRAP_W     = 4,
  localparam int NQ         = 2,
  localparam int NCH        = NQ * CH_PER_QUAD
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  txn_valid_i,
  input  logic                  txn_wr_i,
  input  logic                  dev_a0_i,
  input  logic [7:0]            cmd_i,
  input  logic [1:0]            bidx_i,
  input  logic [7:0]            wdata_i,
  input  logic [STRAP_W-1:0]    strap_i,
  input  logic [7:0]            temp_i,
  input  logic [NCH*MEAS_W-1:0] cur_i,
  input  logic [NCH*MEAS_W-1:0] volt_i,
  output logic [7:0]            rdata_o,
  output logic                  wide_mode_o,
  output logic                  multi_prio_o,
  output logic                  wdog_en_o,
  output logic [7:0]            sram_ctl_o,
  output logic [15:0]           sram_addr_o
);
  reg_route_t  rr;
  meas_route_t mr;
  logic [7:0]  meas_rd;
  logic [7:0]  q_rd   [NQ];
  logic        q_wide [NQ];
  logic        q_mpri [NQ];
  logic        q_wdoff[NQ];
  logic [7:0]  q_sctl [NQ];
  logic [15:0] q_saddr[NQ];
  logic [7:0]  rd_next;

  dq_route u_route (
    .wide_i (wide_mode_o),
    .a0_i   (dev_a0_i),
    .cmd_i  (cmd_i),
    .bidx_i (bidx_i),
    .reg_o  (rr),
    .meas_o (mr)
  );

  dq_meas_mux #(.NCH(NCH), .MEAS_W(MEAS_W)) u_meas (
    .cur_i   (cur_i),
    .volt_i  (volt_i),
    .sel_i   (mr),
    .rdata_o (meas_rd)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    logic wr;
    assign wr = txn_valid_i && txn_wr_i && rr.hit && (rr.quad == q[0]);
    dq_quad_regs #(.QUAD_ID(q), .HAS_SRAM(q == 0), .STRAP_W(STRAP_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr),
      .cmd_i       (cmd_i),
      .wdata_i     (wdata_i),
      .wide_i      (wide_mode_o),
      .strap_i     (strap_i),
      .temp_i      (temp_i),
      .rdata_o     (q_rd[q]),
      .wide_o      (q_wide[q]),
      .mprio_o     (q_mpri[q]),
      .wdog_off_o  (q_wdoff[q]),
      .sram_ctl_o  (q_sctl[q]),
      .sram_addr_o (q_saddr[q])
    );
  end

  // set in either copy enters the mode; both must clear to leave it
  assign wide_mode_o  = q_wide[0] | q_wide[1];
  assign multi_prio_o = q_mpri[0] | q_mpri[1];
  assign wdog_en_o    = !(q_wdoff[0] && q_wdoff[1]);
  assign sram_ctl_o   = q_sctl[0] | q_sctl[1];
  assign sram_addr_o  = q_saddr[0] | q_saddr[1];

  always_comb begin
    if (mr.hit)      rd_next = meas_rd;
    else if (rr.hit) rd_next = q_rd[rr.quad];
    else             rd_next = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rdata_o <= 8'h00;
    else if (txn_valid_i && !txn_wr_i) rdata_o <= rd_next;
  end

  // R13
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(txn_valid_i && !txn_wr_i) |=> $stable(rdata_o));

  // R2
  wide_a0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && !txn_wr_i && wide_mode_o && dev_a0_i) |=> (rdata_o == 8'h00));

  // R12
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && !txn_wr_i && cmd_i[7]) |=> (rdata_o == 8'h00));

  // R10
  sram_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && txn_wr_i && !wide_mode_o && dev_a0_i)
    |=> ($stable(sram_ctl_o) && $stable(sram_addr_o)));

  // R5
  pin_a0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && !txn_wr_i && !wide_mode_o && cmd_i == CMD_PIN && bidx_i == 2'd0)
    |=> (rdata_o[0] == $past(dev_a0_i)));
endmodule

// File: tb/tb_dq_reg_mapper.sv
`timescale 1ns/1ps
module tb_dq_reg_mapper;
  localparam int NCH = 8;
  localparam int MW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, wr = 1'b0, a0 = 1'b0;
  logic [7:0] cmd = '0, wd = '0;
  logic [1:0] bi = '0;
  logic [3:0] strap = 4'hA;
  logic [7:0] temp = 8'h5C;
  logic [NCH*MW-1:0] cur_f, volt_f;
  logic [7:0] rdata;
  logic wide_o, mpri_o, wden_o;
  logic [7:0] sctl_o;
  logic [15:0] saddr_o;

  int checks = 0, errors = 0;

  logic [15:0] cur_m [NCH];
  logic [15:0] volt_m[NCH];
  logic [7:0] m_gm[2], m_wd[2], m_sctl;
  logic [15:0] m_saddr;

  always #4 clk = ~clk;

  dq_reg_mapper dut (
    .clk_i(clk), .rst_ni(rst_n), .txn_valid_i(vld), .txn_wr_i(wr), .dev_a0_i(a0),
    .cmd_i(cmd), .bidx_i(bi), .wdata_i(wd), .strap_i(strap), .temp_i(temp),
    .cur_i(cur_f), .volt_i(volt_f), .rdata_o(rdata), .wide_mode_o(wide_o),
    .multi_prio_o(mpri_o), .wdog_en_o(wden_o), .sram_ctl_o(sctl_o), .sram_addr_o(saddr_o)
  );

  function automatic logic m_wide();
    return m_gm[0][0] | m_gm[1][0];
  endfunction

  // returns 1 when an 8-bit register access is answered, with the quad in q
  function automatic logic reg_dec(input logic xa0, input logic [1:0] xb, output logic q);
    q = 1'b0;
    if (!m_wide()) begin q = xa0; return xb == 2'd0; end
    q = xb[0];
    return !xa0 && !xb[1];
  endfunction

  function automatic logic [7:0] exp_rd(input logic xa0, input logic [7:0] c, input logic [1:0] xb);
    logic q, ok;
    logic [2:0] ch;
    logic [15:0] v;
    if (c[7:4] == 4'h3) begin
      if (!m_wide()) begin
        if (c[0] || xb[1]) return 8'h00;
        q = xa0;
      end else begin
        if (xa0 || (c[0] && xb[1])) return 8'h00;
        q = c[0] | xb[1];
      end
      ch = {q, c[3:2]};
      v = c[1] ? volt_m[ch] : cur_m[ch];
      return xb[0] ? v[15:8] : v[7:0];
    end
    ok = reg_dec(xa0, xb, q);
    if (!ok) return 8'h00;
    case (c)
      8'h17: return m_gm[q];
      8'h42: return m_wd[q];
      8'h11: return {3'b000, strap, (m_wide() ? 1'b0 : q)};
      8'h2C: return temp;
      8'h60: return q ? 8'h00 : m_sctl;
      8'h62: return q ? 8'h00 : m_saddr[7:0];
      8'h63: return q ? 8'h00 : m_saddr[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic xa0, input logic [7:0] c, input logic [1:0] xb, input logic [7:0] d);
    logic q, ok;
    if (c[7:4] == 4'h3) return;
    ok = reg_dec(xa0, xb, q);
    if (!ok) return;
    case (c)
      8'h17: m_gm[q] = d;
      8'h42: m_wd[q] = d;
      8'h60: if (!q) m_sctl = d;
      8'h62: if (!q) m_saddr[7:0] = d;
      8'h63: if (!q) m_saddr[15:8] = d;
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R3 wide"}, 32'(wide_o), 32'(m_wide()));
    chk({tag, " R4 mprio"}, 32'(mpri_o), 32'(m_gm[0][1] | m_gm[1][1]));
    chk({tag, " R9 wdog"}, 32'(wden_o), 32'((m_wd[0][3:0] != 4'hB) || (m_wd[1][3:0] != 4'hB)));
    chk({tag, " R10 sram"}, {8'h00, sctl_o, saddr_o}, {8'h00, m_sctl, m_saddr});
  endtask

  task automatic do_wr(input logic xa0, input logic [7:0] c, input logic [1:0] xb, input logic [7:0] d);
    @(negedge clk);
    vld = 1'b1; wr = 1'b1; a0 = xa0; cmd = c; bi = xb; wd = d;
    m_write(xa0, c, xb, d);
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
  endtask

  task automatic do_rd(input string tag, input logic xa0, input logic [7:0] c, input logic [1:0] xb);
    logic [7:0] e;
    @(negedge clk);
    vld = 1'b1; wr = 1'b0; a0 = xa0; cmd = c; bi = xb;
    e = exp_rd(xa0, c, xb);
    @(negedge clk);
    vld = 1'b0;
    chk($sformatf("%s cmd=%0h a0=%0d b=%0d", tag, c, xa0, xb), 32'(rdata), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [7:0] pool [16];
    logic [7:0] held;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int c = 0; c < NCH; c++) begin
      cur_m[c]  = 16'($urandom);
      volt_m[c] = 16'($urandom);
      cur_f[c*MW +: MW]  = cur_m[c];
      volt_f[c*MW +: MW] = volt_m[c];
    end
    m_gm[0] = 8'h80; m_gm[1] = 8'h80; m_wd[0] = 8'h0B; m_wd[1] = 8'h0B;
    m_sctl = 8'h00; m_saddr = 16'h0000;
    pool = '{8'h11, 8'h17, 8'h2C, 8'h42, 8'h60, 8'h62, 8'h63, 8'h30,
             8'h31, 8'h36, 8'h3B, 8'h3C, 8'h3F, 8'h7F, 8'h05, 8'hC2};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk_outs("reset");
    chk("R13 reset rdata", 32'(rdata), 32'h0);
    do_rd("R3 reset gm lower", 1'b0, 8'h17, 2'd0);
    do_rd("R3 reset gm upper", 1'b1, 8'h17, 2'd0);
    do_rd("R9 reset wd upper", 1'b1, 8'h42, 2'd0);

    // narrow mode
    do_rd("R5 pin narrow lower", 1'b0, 8'h11, 2'd0);
    do_rd("R5 pin narrow upper", 1'b1, 8'h11, 2'd0);
    do_rd("R1 narrow byte1", 1'b0, 8'h17, 2'd1);
    do_wr(1'b0, 8'h17, 2'd2, 8'hFF);
    chk_outs("R1 narrow write idx2");
    do_rd("R11 temp lower", 1'b0, 8'h2C, 2'd0);
    do_rd("R11 temp upper", 1'b1, 8'h2C, 2'd0);
    do_wr(1'b0, 8'h2C, 2'd0, 8'h00);
    do_rd("R11 temp after write", 1'b0, 8'h2C, 2'd0);
    do_rd("R6 cur ch1 lo", 1'b0, 8'h34, 2'd0);
    do_rd("R6 volt ch7 hi", 1'b1, 8'h3E, 2'd1);
    do_rd("R6 odd narrow", 1'b0, 8'h31, 2'd0);
    do_rd("R6 idx2 narrow", 1'b0, 8'h30, 2'd2);

    // sram lower only
    do_wr(1'b0, 8'h60, 2'd0, 8'h3C);
    do_wr(1'b0, 8'h63, 2'd0, 8'h12);
    do_wr(1'b0, 8'h62, 2'd0, 8'h34);
    chk_outs("R10 lower write");
    do_wr(1'b1, 8'h60, 2'd0, 8'hFF);
    do_wr(1'b1, 8'h62, 2'd0, 8'hFF);
    chk_outs("R10 upper write ignored");
    do_rd("R10 upper read", 1'b1, 8'h60, 2'd0);
    do_rd("R10 lower read", 1'b0, 8'h63, 2'd0);

    // watchdog merge
    do_wr(1'b1, 8'h42, 2'd0, 8'hFA);
    chk_outs("R9 upper field moved");
    do_wr(1'b1, 8'h42, 2'd0, 8'h5B);
    chk_outs("R9 field back to 1011");

    // mode merge: set in upper, clear needs both
    do_wr(1'b1, 8'h17, 2'd0, 8'h81);
    chk_outs("R3 upper set");
    do_rd("R2 wide byte1 upper gm", 1'b0, 8'h17, 2'd1);
    do_rd("R5 pin wide byte1", 1'b0, 8'h11, 2'd1);
    do_rd("R2 wide a0=1 read", 1'b1, 8'h17, 2'd0);
    do_wr(1'b1, 8'h17, 2'd1, 8'h00);
    chk_outs("R2 wide a0=1 write ignored");
    do_wr(1'b0, 8'h17, 2'd0, 8'h83);
    chk_outs("R4 lower mprio set");
    do_rd("R7 wide even b0", 1'b0, 8'h38, 2'd0);
    do_rd("R7 wide even b1", 1'b0, 8'h38, 2'd1);
    do_rd("R7 wide even b2", 1'b0, 8'h38, 2'd2);
    do_rd("R7 wide even b3", 1'b0, 8'h3A, 2'd3);
    do_rd("R8 wide odd b0", 1'b0, 8'h33, 2'd0);
    do_rd("R8 wide odd b1", 1'b0, 8'h3D, 2'd1);
    do_rd("R8 wide odd b2", 1'b0, 8'h3D, 2'd2);
    do_rd("R2 wide idx3 reg", 1'b0, 8'h42, 2'd3);
    do_wr(1'b0, 8'h17, 2'd1, 8'h80);
    chk_outs("R3 only upper cleared");
    do_wr(1'b0, 8'h17, 2'd0, 8'h80);
    chk_outs("R3 both cleared");

    // unmapped and hold
    do_wr(1'b0, 8'h7F, 2'd0, 8'hAA);
    do_rd("R12 unmapped", 1'b0, 8'h7F, 2'd0);
    do_rd("R13 load", 1'b0, 8'h42, 2'd0);
    held = rdata;
    do_wr(1'b0, 8'h05, 2'd0, 8'h11);
    repeat (3) @(negedge clk);
    chk("R13 hold", 32'(rdata), 32'(held));

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic xa0;
      logic [7:0] c;
      logic [1:0] xb;
      xa0 = 1'($urandom);
      c   = pool[$urandom % 16];
      xb  = 2'($urandom);
      if (($urandom % 10) < 3) begin
        do_wr(xa0, c, xb, 8'($urandom));
        chk_outs("rand");
      end else begin
        do_rd("R1 R6 rand", xa0, c, xb);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule